// File: doc/BRIEF.md
# Dual-Output Masked Interrupt Controller

This block gathers 32 level-sensitive interrupt sources and presents them on two processor-facing lines: a normal interrupt line and a fast interrupt line. Each line has its own enable mask over the same raw source levels. Software changes a mask through a pair of registers: one sets the bits written as 1, the other clears them. A software-controlled bit can raise source 0 without any hardware request. Both outputs are combinational ORs of the masked levels, so a source shows up on an output in the same cycle that it and its enable bit are both high.

Software reaches the block through a simple 32-bit register bus with word offsets. An access occupies one cycle with `req_i` high. The response (`rdata_o` and `err_o`) is registered and appears in the following cycle. The bus has no back-pressure: every request is accepted in its own cycle. An illegal access leaves all state unchanged, returns zero and raises `err_o` for that response cycle. Controllers can be cascaded by wiring one instance's `irq_o` into a source input of another.

Top module: `intc_dual`

## Requirements
- R1: Reading word 1 or word 9 returns the raw level vector. That vector is `src_i` with bit 0 ORed with the software source bit.
- R2: `irq_o` is high exactly when (raw AND IRQ enable) is non-zero. `fiq_o` is high exactly when (raw AND FIQ enable) is non-zero. Both follow `src_i` in the same cycle.
- R3: Reading word 0 returns raw AND IRQ enable. Reading word 8 returns raw AND FIQ enable.
- R4: Writing word 2 ORs the write data into the IRQ enable mask, and writing word 10 does the same for the FIQ enable mask. Reading word 2 or word 10 returns that mask. The new mask takes effect in the cycle after the write.
- R5: Writing word 3 clears the IRQ enable bits that are 1 in the write data, and writing word 11 does the same for the FIQ enable mask. Other bits are kept.
- R6: Writing word 4 with data bit 0 = 1 sets the software source bit. Writing word 5 with data bit 0 = 1 clears it. Writing either word with bit 0 = 0 leaves the bit as it is. The bit holds until it is cleared. Reading word 4 returns the bit in bit 0, with zeros above it.
- R7: These accesses are illegal: a read of word 3, 5, 11 or any unmapped word; a write of word 0, 1, 8, 9 or any unmapped word. An illegal access changes no state. Its response has `rdata_o` = 0 and `err_o` = 1.
- R8: After reset, both enable masks and the software bit are zero, so `irq_o` and `fiq_o` are low whatever `src_i` holds.
- R9: The response appears one cycle after the request. A legal read returns the state from before that edge. A legal write returns `rdata_o` = 0 with `err_o` = 0. A cycle with no request gives `rdata_o` = 0 and `err_o` = 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | 32 | Level-sensitive interrupt sources |
| req_i | input | 1 | Bus access in this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 4 | Word offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, one cycle after the request |
| err_o | output | 1 | Illegal-access flag, one cycle after the request |
| irq_o | output | 1 | Normal interrupt line |
| fiq_o | output | 1 | Fast interrupt line |

## Verification
The assertions assume that `src_i` is synchronous to `clk` and that `we_i`, `addr_i` and `wdata_i` hold known values whenever `req_i` is high. They also assume at most one access per cycle, which the port list enforces. The bench drives every input at the falling edge and holds it through the next rising edge. It samples the response and both output lines at the following falling edge. Its random offsets cover the whole 4-bit space, so unmapped words are part of the stimulus.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int OFF_W = 4;
  localparam int N_CH  = 2;
  localparam int CH_IRQ = 0;
  localparam int CH_FIQ = 1;

  localparam logic [OFF_W-1:0] OFF_IRQ_STAT = 4'd0;
  localparam logic [OFF_W-1:0] OFF_RAW_A    = 4'd1;
  localparam logic [OFF_W-1:0] OFF_IRQ_EN   = 4'd2;
  localparam logic [OFF_W-1:0] OFF_IRQ_DIS  = 4'd3;
  localparam logic [OFF_W-1:0] OFF_SOFT_ON  = 4'd4;
  localparam logic [OFF_W-1:0] OFF_SOFT_OFF = 4'd5;
  localparam logic [OFF_W-1:0] OFF_FIQ_STAT = 4'd8;
  localparam logic [OFF_W-1:0] OFF_RAW_B    = 4'd9;
  localparam logic [OFF_W-1:0] OFF_FIQ_EN   = 4'd10;
  localparam logic [OFF_W-1:0] OFF_FIQ_DIS  = 4'd11;

  typedef enum logic [2:0] {
    RD_NONE, RD_MASK_I, RD_RAW, RD_EN_I, RD_SOFT, RD_MASK_F, RD_EN_F
  } rd_sel_e;
endpackage

// File: rtl/intc_decode.sv
module intc_decode
  import intc_pkg::*;
(
  input  logic             req_i,
  input  logic             we_i,
  input  logic [OFF_W-1:0] addr_i,
  output logic [N_CH-1:0]  set_o,
  output logic [N_CH-1:0]  clr_o,
  output logic             soft_on_o,
  output logic             soft_off_o,
  output rd_sel_e          rd_sel_o,
  output logic             illegal_o
);
  always_comb begin
    set_o      = '0;
    clr_o      = '0;
    soft_on_o  = 1'b0;
    soft_off_o = 1'b0;
    rd_sel_o   = RD_NONE;
    illegal_o  = 1'b0;
    if (req_i) begin
      if (we_i) begin
        case (addr_i)
          OFF_IRQ_EN:   set_o[CH_IRQ] = 1'b1;
          OFF_IRQ_DIS:  clr_o[CH_IRQ] = 1'b1;
          OFF_FIQ_EN:   set_o[CH_FIQ] = 1'b1;
          OFF_FIQ_DIS:  clr_o[CH_FIQ] = 1'b1;
          OFF_SOFT_ON:  soft_on_o     = 1'b1;
          OFF_SOFT_OFF: soft_off_o    = 1'b1;
          default:      illegal_o     = 1'b1;
        endcase
      end else begin
        case (addr_i)
          OFF_IRQ_STAT: rd_sel_o = RD_MASK_I;
          OFF_RAW_A,
          OFF_RAW_B:    rd_sel_o = RD_RAW;
          OFF_IRQ_EN:   rd_sel_o = RD_EN_I;
          OFF_SOFT_ON:  rd_sel_o = RD_SOFT;
          OFF_FIQ_STAT: rd_sel_o = RD_MASK_F;
          OFF_FIQ_EN:   rd_sel_o = RD_EN_F;
          default:      illegal_o = 1'b1;
        endcase
      end
    end
  end
endmodule

// File: rtl/intc_mask.sv
module intc_mask #(
  parameter int N_SRC = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_i,
  input  logic             clr_i,
  input  logic [N_SRC-1:0] wdata_i,
  input  logic [N_SRC-1:0] raw_i,
  output logic [N_SRC-1:0] en_o,
  output logic [N_SRC-1:0] masked_o,
  output logic             line_o
);
  logic [N_SRC-1:0] en_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     en_q <= '0;
    else if (set_i) en_q <= en_q | wdata_i;
    else if (clr_i) en_q <= en_q & ~wdata_i;
  end

  assign en_o     = en_q;
  assign masked_o = raw_i & en_q;
  assign line_o   = |masked_o;

  // R4
  en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> ((en_q & $past(wdata_i)) == $past(wdata_i)) && ((en_q & ~$past(wdata_i)) == ($past(en_q) & ~$past(wdata_i))));
  // R5
  en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> ((en_q & $past(wdata_i)) == '0) && ((en_q & ~$past(wdata_i)) == ($past(en_q) & ~$past(wdata_i))));
  // R7
  en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && !clr_i) |=> $stable(en_q));
  // R8
  en_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) == 1'b0) |-> (en_q == '0));
endmodule

// File: rtl/intc_soft.sv
module intc_soft (
  input  logic clk,
  input  logic rst_n,
  input  logic on_i,
  input  logic off_i,
  input  logic bit0_i,
  output logic soft_o
);
  logic soft_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                soft_q <= 1'b0;
    else if (on_i && bit0_i)   soft_q <= 1'b1;
    else if (off_i && bit0_i)  soft_q <= 1'b0;
  end

  assign soft_o = soft_q;

  // R6
  soft_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (on_i && bit0_i) |=> soft_q);
  // R6
  soft_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (off_i && bit0_i && !on_i) |=> !soft_q);
  // R6
  soft_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !((on_i || off_i) && bit0_i) |=> $stable(soft_q));
endmodule

// File: rtl/intc_dual.sv
module intc_dual
  import intc_pkg::*;
#(
  parameter int N_SRC = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_i,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [OFF_W-1:0] addr_i,
  input  logic [N_SRC-1:0] wdata_i,
  output logic [N_SRC-1:0] rdata_o,
  output logic             err_o,
  output logic             irq_o,
  output logic             fiq_o
);
  localparam int HI_W = N_SRC - 1;

  logic [N_CH-1:0]  set_s, clr_s, line_s;
  logic             soft_on_s, soft_off_s, illegal_s, soft_s;
  rd_sel_e          rd_sel_s;
  logic [N_SRC-1:0] raw_s, rd_val;
  logic [N_SRC-1:0] en_s     [N_CH];
  logic [N_SRC-1:0] masked_s [N_CH];
  logic [N_SRC-1:0] rdata_q;
  logic             err_q;

  intc_decode u_dec (
    .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
    .set_o(set_s), .clr_o(clr_s),
    .soft_on_o(soft_on_s), .soft_off_o(soft_off_s),
    .rd_sel_o(rd_sel_s), .illegal_o(illegal_s)
  );

  intc_soft u_soft (
    .clk(clk), .rst_n(rst_n), .on_i(soft_on_s), .off_i(soft_off_s),
    .bit0_i(wdata_i[0]), .soft_o(soft_s)
  );

  assign raw_s = src_i | {{HI_W{1'b0}}, soft_s};

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    intc_mask #(.N_SRC(N_SRC)) u_mask (
      .clk(clk), .rst_n(rst_n), .set_i(set_s[c]), .clr_i(clr_s[c]),
      .wdata_i(wdata_i), .raw_i(raw_s),
      .en_o(en_s[c]), .masked_o(masked_s[c]), .line_o(line_s[c])
    );
  end

  assign irq_o = line_s[CH_IRQ];
  assign fiq_o = line_s[CH_FIQ];

  always_comb begin
    case (rd_sel_s)
      RD_MASK_I: rd_val = masked_s[CH_IRQ];
      RD_MASK_F: rd_val = masked_s[CH_FIQ];
      RD_RAW:    rd_val = raw_s;
      RD_EN_I:   rd_val = en_s[CH_IRQ];
      RD_EN_F:   rd_val = en_s[CH_FIQ];
      RD_SOFT:   rd_val = {{HI_W{1'b0}}, soft_s};
      default:   rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      rdata_q <= rd_val;
      err_q   <= illegal_s;
    end
  end

  assign rdata_o = rdata_q;
  assign err_o   = err_q;

  // R7
  bad_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !we_i && (addr_i == OFF_IRQ_DIS || addr_i == OFF_SOFT_OFF || addr_i == OFF_FIQ_DIS))
      |=> (err_o && rdata_o == '0));
  // R7
  bad_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && we_i && (addr_i == OFF_IRQ_STAT || addr_i == OFF_RAW_A || addr_i == OFF_FIQ_STAT || addr_i == OFF_RAW_B))
      |=> (err_o && rdata_o == '0));
  // R9
  idle_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |=> (!err_o && rdata_o == '0));
  // R8
  out_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) == 1'b0) |-> (!irq_o && !fiq_o));
  // R2
  src_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_i == '0 && !soft_s) |-> (!irq_o && !fiq_o));
endmodule

// File: tb/intc_dual_tb_top.sv
module intc_dual_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] src_i;
  logic        req_i, we_i;
  logic [3:0]  addr_i;
  logic [31:0] wdata_i;
  logic [31:0] rdata_o;
  logic        err_o, irq_o, fiq_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [31:0] m_irq, m_fiq;
  logic        m_soft;

  always #10 clk = ~clk;

  intc_dual dut_i (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .err_o(err_o),
    .irq_o(irq_o), .fiq_o(fiq_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit legal(input logic we, input logic [3:0] a);
    if (we) return (a == 2 || a == 3 || a == 4 || a == 5 || a == 10 || a == 11);
    return (a == 0 || a == 1 || a == 2 || a == 4 || a == 8 || a == 9 || a == 10);
  endfunction

  function automatic logic [31:0] exp_rd(input logic [3:0] a, input logic [31:0] raw);
    case (a)
      4'd0:        return raw & m_irq;
      4'd1, 4'd9:  return raw;
      4'd2:        return m_irq;
      4'd4:        return {31'b0, m_soft};
      4'd8:        return raw & m_fiq;
      4'd10:       return m_fiq;
      default:     return 32'h0;
    endcase
  endfunction

  function automatic string rd_tag(input logic [3:0] a);
    case (a)
      4'd0, 4'd8:  return "R3 masked status";
      4'd1, 4'd9:  return "R1 raw status";
      4'd2, 4'd10: return "R4 enable readback";
      4'd4:        return "R6 soft readback";
      default:     return "R7 illegal read data";
    endcase
  endfunction

  task automatic model_wr(input logic [3:0] a, input logic [31:0] d);
    case (a)
      4'd2:  m_irq = m_irq | d;
      4'd3:  m_irq = m_irq & ~d;
      4'd10: m_fiq = m_fiq | d;
      4'd11: m_fiq = m_fiq & ~d;
      4'd4:  if (d[0]) m_soft = 1'b1;
      4'd5:  if (d[0]) m_soft = 1'b0;
      default: ;
    endcase
  endtask

  task automatic check_lines(input logic [31:0] s);
    logic [31:0] raw;
    raw = s | {31'b0, m_soft};
    chk(irq_o == |(raw & m_irq), "R2 irq_o", {31'b0, irq_o}, {31'b0, |(raw & m_irq)});
    chk(fiq_o == |(raw & m_fiq), "R2 fiq_o", {31'b0, fiq_o}, {31'b0, |(raw & m_fiq)});
  endtask

  // Drive at the falling edge, respond checked at the next falling edge.
  task automatic acc(input logic we, input logic [3:0] a, input logic [31:0] d, input logic [31:0] s);
    logic [31:0] raw, e_d;
    logic        ok;
    raw     = s | {31'b0, m_soft};
    ok      = legal(we, a);
    e_d     = (!we && ok) ? exp_rd(a, raw) : 32'h0;
    src_i   = s;
    req_i   = 1'b1;
    we_i    = we;
    addr_i  = a;
    wdata_i = d;
    @(posedge clk);
    if (we && ok) model_wr(a, d);
    @(negedge clk);
    req_i = 1'b0;
    if (we) chk(rdata_o == e_d, ok ? "R9 write returns zero" : "R7 illegal write data", rdata_o, e_d);
    else    chk(rdata_o == e_d, rd_tag(a), rdata_o, e_d);
    chk(err_o == !ok, "R7 err_o", {31'b0, err_o}, {31'b0, !ok});
    check_lines(s);
  endtask

  task automatic idle(input logic [31:0] s);
    src_i = s;
    req_i = 1'b0;
    @(negedge clk);
    chk(err_o == 1'b0 && rdata_o == 32'h0, "R9 idle response", rdata_o, 32'h0);
    check_lines(s);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    logic [3:0]  a;
    logic [31:0] d, s;
    seed = 32'd1234;
    void'($urandom(seed));
    m_irq = '0; m_fiq = '0; m_soft = 1'b0;
    rst_n = 1'b0; req_i = 1'b0; we_i = 1'b0; addr_i = '0; wdata_i = '0; src_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    src_i = 32'hFFFF_FFFF;
    @(negedge clk);
    // R8 reset state
    chk(!irq_o && !fiq_o, "R8 lines low after reset", {30'b0, irq_o, fiq_o}, 32'h0);
    acc(1'b0, 4'd2, 32'h0, 32'hFFFF_FFFF);
    acc(1'b0, 4'd10, 32'h0, 32'hFFFF_FFFF);
    acc(1'b0, 4'd4, 32'h0, 32'h0);

    // R4/R5 directed
    acc(1'b1, 4'd2, 32'hFFFF_FFFF, 32'h0);
    acc(1'b1, 4'd3, 32'h0000_FFFF, 32'h0);
    acc(1'b0, 4'd2, 32'h0, 32'h0001_0000);
    chk(m_irq == 32'hFFFF_0000, "R5 model mask", m_irq, 32'hFFFF_0000);
    acc(1'b1, 4'd10, 32'h0000_0081, 32'h0000_0080);
    acc(1'b1, 4'd11, 32'h0000_0080, 32'h0000_0080);
    acc(1'b0, 4'd10, 32'h0, 32'h0000_0080);

    // R6 soft source persists, zero bit 0 has no effect
    acc(1'b1, 4'd4, 32'h1, 32'h0);
    idle(32'h0);
    idle(32'h0);
    acc(1'b1, 4'd5, 32'hFFFF_FFFE, 32'h0);
    acc(1'b0, 4'd1, 32'h0, 32'h0);
    acc(1'b0, 4'd8, 32'h0, 32'h0);
    acc(1'b1, 4'd5, 32'h1, 32'h0);
    acc(1'b0, 4'd4, 32'h0, 32'h0);

    // R7 illegal writes leave masks untouched
    acc(1'b1, 4'd0, 32'hFFFF_FFFF, 32'h0);
    acc(1'b1, 4'd9, 32'hFFFF_FFFF, 32'h0);
    acc(1'b1, 4'd7, 32'hFFFF_FFFF, 32'h0);
    acc(1'b0, 4'd2, 32'h0, 32'h0);
    acc(1'b0, 4'd10, 32'h0, 32'h0);
    acc(1'b0, 4'd11, 32'h0, 32'h0);

    // Random mix
    for (int i = 0; i < 600; i++) begin
      a = 4'($urandom_range(0, 15));
      d = $urandom();
      if ($urandom_range(0, 3) == 0) d = d & 32'h0000_0003;
      s = $urandom() & $urandom();
      if ($urandom_range(0, 4) == 0) s = 32'h0;
      acc(1'($urandom_range(0, 1)), a, d, s);
      if ($urandom_range(0, 7) == 0) idle(s);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule